// File: doc/BRIEF.md
# Wait-State Memory Target for AHB-Lite

This block is a bus target on an AHB-Lite style pipelined bus. It holds a small memory built from flip-flops. Every accepted read or write has its data phase stretched by a fixed, parameter-set number of wait cycles. The address and control of a transfer are taken in the cycle they appear on the bus. That happens only when the target is selected, the bus-wide ready is high and the transfer type carries data. The data phase then runs through a small state machine, which drives the ready and response outputs from its state.

The state machine has five states:
- `ST_IDLE`: no data phase is pending. Ready is high and the response is OKAY.
- `ST_WAIT`: a wait cycle. Ready is low.
- `ST_DONE`: the completing data cycle. Ready is high, a write is committed and read data is driven.
- `ST_ERR1`: the first cycle of an error response. Ready is low and the response is ERROR.
- `ST_ERR2`: the second cycle of an error response. Ready is high and the response is ERROR.

The transitions are:
- From `ST_IDLE`, `ST_DONE` or `ST_ERR2`, a valid accepted transfer goes to `ST_WAIT`. When the wait count is zero it goes straight to `ST_DONE`.
- From the same three states, an accepted faulty transfer goes to `ST_ERR1`.
- From the same three states, anything else goes to `ST_IDLE`.
- `ST_WAIT` stays in `ST_WAIT` until its counter is used up, then moves to `ST_DONE`.
- `ST_ERR1` always moves to `ST_ERR2`.

Writes update only the byte lanes picked by the transfer size and the low address bits, in little-endian order. A transfer is faulty when it falls outside the memory, is misaligned, or is wider than the data bus. A faulty transfer gets the two-cycle error response and leaves the memory unchanged.

Top module: `ahbl_wait_mem`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `s_ready_out` is 1 and `s_resp` is 0. Reset clears every memory word to zero.
- R2: A transfer is taken only in a cycle where `s_sel`=1, `s_ready_in`=1 and `s_trans` is NONSEQ (2'b10) or SEQ (2'b11). A transfer shown while `s_ready_in` is low, and withdrawn before it rises, starts nothing and writes nothing.
- R3: An accepted, in-range, aligned transfer holds `s_ready_out` low for exactly WAIT_STATES cycles. It then has one cycle with `s_ready_out`=1 and `s_resp`=0.
- R4: A write takes `s_wdata` in its completing cycle and updates only the byte lanes chosen as follows:
  - `s_size`=0 (byte) writes lane `addr[1:0]`.
  - `s_size`=1 (halfword) writes lanes `addr[1:0]` and `addr[1:0]+1`.
  - `s_size`=2 (word) writes all four lanes.
  Lane k is `wdata[8k+7:8k]`. Other bytes keep their values.
- R5: In the completing cycle of a read, `s_rdata` carries the full word at index `addr/4`, whatever the size.
- R6: A transfer is faulty in any of these cases: its address is at least MEM_WORDS*4, its address is not a multiple of its size in bytes, or `s_size`>2. A faulty transfer gives one cycle with `s_ready_out`=0 and `s_resp`=1, then one cycle with `s_ready_out`=1 and `s_resp`=1. The memory is not written.
- R7: IDLE (2'b00) and BUSY (2'b01) transfer types get a zero-wait OKAY in the next cycle and cause no write.
- R8: A new transfer shown in the completing cycle of the previous one is taken at that edge. The previous write still commits.
- R9: Pulling `rst_n` low during a stretched data phase drives `s_ready_out` high at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| s_sel | input | 1 | Target select from the address decoder |
| s_addr | input | ADDR_W | Byte address of the address phase |
| s_trans | input | 2 | Transfer type: IDLE, BUSY, NONSEQ, SEQ |
| s_write | input | 1 | 1 = write, 0 = read |
| s_size | input | 3 | Transfer size as log2 of the byte count |
| s_wdata | input | DATA_W | Write data, valid in the data phase |
| s_ready_in | input | 1 | Bus-wide ready; high ends the previous data phase |
| s_ready_out | output | 1 | Ready of this target; low inserts a wait cycle |
| s_resp | output | 1 | 0 = OKAY, 1 = ERROR |
| s_rdata | output | DATA_W | Read data, valid in the completing cycle |

## Verification
The hardest case to reach from the ports is an address phase that is on the bus while the bus-wide ready is held low by some other target. This target must not latch that phase. The bench breaks the usual loop-back of ready: it forces `s_ready_in` low, presents a word write with select and NONSEQ, then withdraws it before ready returns. It then reads the word back and expects it unchanged. The bench also overlaps a write's completing cycle with the next read, and pulls reset inside a wait cycle, to cover the pipelined hand-over and the asynchronous reset.

// File: rtl/ahbl_mem_pkg.sv
package ahbl_mem_pkg;

    // Data-phase states of the target
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_DONE,
        ST_ERR1,
        ST_ERR2
    } dphase_t;

    // Transfer-type codes
    localparam logic [1:0] TR_IDLE   = 2'b00;
    localparam logic [1:0] TR_BUSY   = 2'b01;
    localparam logic [1:0] TR_NONSEQ = 2'b10;
    localparam logic [1:0] TR_SEQ    = 2'b11;

endpackage

// File: rtl/ahbl_lane_dec.sv
module ahbl_lane_dec #(
    parameter int STRB_W = 4,
    parameter int OFS_W  = 2
) (
    input  logic [2:0]        size,
    input  logic [OFS_W-1:0]  ofs,
    output logic [STRB_W-1:0] lanes,
    output logic              misfit
);

    // Lanes [ofs, ofs+bytes) in little-endian order; misfit when the size
    // exceeds the bus or the offset is not a multiple of the size.
    always_comb begin
        int nbytes;
        int start;
        nbytes = 1 << size;
        start  = int'(ofs);
        misfit = (nbytes > STRB_W) || ((start % nbytes) != 0);
        for (int b = 0; b < STRB_W; b++) begin
            lanes[b] = !misfit && (b >= start) && (b < start + nbytes);
        end
    end

endmodule

// File: rtl/ahbl_reg_bank.sv
module ahbl_reg_bank #(
    parameter int WORDS  = 16,
    parameter int DATA_W = 32,
    parameter int STRB_W = DATA_W / 8,
    parameter int IDX_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [STRB_W-1:0] lanes,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] bank [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) begin
                bank[w] <= '0;
            end
        end else if (we) begin
            for (int b = 0; b < STRB_W; b++) begin
                if (lanes[b]) begin
                    bank[widx][b*8 +: 8] <= wdata[b*8 +: 8];
                end
            end
        end
    end

    assign rdata = bank[ridx];

endmodule

// File: rtl/ahbl_wait_mem.sv
module ahbl_wait_mem
    import ahbl_mem_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int MEM_WORDS   = 16,
    parameter int WAIT_STATES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_sel,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [1:0]        s_trans,
    input  logic              s_write,
    input  logic [2:0]        s_size,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic              s_ready_in,
    output logic              s_ready_out,
    output logic              s_resp,
    output logic [DATA_W-1:0] s_rdata
);

    localparam int STRB_W    = DATA_W / 8;
    localparam int OFS_W     = $clog2(STRB_W);
    localparam int IDX_W     = $clog2(MEM_WORDS);
    localparam longint BYTE_SPAN = longint'(MEM_WORDS) * STRB_W;
    localparam int CNT_W     = (WAIT_STATES > 1) ? $clog2(WAIT_STATES) : 1;
    localparam dphase_t FIRST_DATA = (WAIT_STATES == 0) ? ST_DONE : ST_WAIT;

    dphase_t             state_q, state_d;
    logic                data_kind;
    logic                take;
    logic                start_ok;
    logic                start_bad;
    logic                out_of_range;
    logic                misfit;
    logic [STRB_W-1:0]   lanes_now;
    logic                wait_last;

    logic                cap_write;
    logic [STRB_W-1:0]   cap_lanes;
    logic [IDX_W-1:0]    cap_idx;

    logic                mem_we;
    logic [DATA_W-1:0]   mem_rdata;

    // ---------------- address-phase qualification ----------------
    assign data_kind    = (s_trans == TR_NONSEQ) || (s_trans == TR_SEQ);
    assign take         = s_sel && s_ready_in && s_ready_out && data_kind;
    assign out_of_range = (s_addr >= ADDR_W'(BYTE_SPAN));
    assign start_bad    = take && (out_of_range || misfit);
    assign start_ok     = take && !out_of_range && !misfit;

    ahbl_lane_dec #(
        .STRB_W (STRB_W),
        .OFS_W  (OFS_W)
    ) u_lane_dec (
        .size   (s_size),
        .ofs    (s_addr[OFS_W-1:0]),
        .lanes  (lanes_now),
        .misfit (misfit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_write <= 1'b0;
            cap_lanes <= '0;
            cap_idx   <= '0;
        end else if (start_ok) begin
            cap_write <= s_write;
            cap_lanes <= lanes_now;
            cap_idx   <= s_addr[OFS_W +: IDX_W];
        end
    end

    // ---------------- wait counter (variant by parameter) ----------------
    if (WAIT_STATES > 0) begin : g_wait
        logic [CNT_W-1:0] cnt_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (start_ok) begin
                cnt_q <= CNT_W'(WAIT_STATES - 1);
            end else if (state_q == ST_WAIT && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
        assign wait_last = (cnt_q == '0);
    end else begin : g_nowait
        assign wait_last = 1'b1;
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_ERR2: begin
                if (start_bad) begin
                    state_d = ST_ERR1;
                end else if (start_ok) begin
                    state_d = FIRST_DATA;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_WAIT: state_d = wait_last ? ST_DONE : ST_WAIT;
            ST_ERR1: state_d = ST_ERR2;
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        s_ready_out = 1'b1;
        s_resp      = 1'b0;
        mem_we      = 1'b0;
        s_rdata     = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WAIT: s_ready_out = 1'b0;
            ST_DONE: begin
                mem_we  = cap_write;
                s_rdata = cap_write ? '0 : mem_rdata;
            end
            ST_ERR1: begin
                s_ready_out = 1'b0;
                s_resp      = 1'b1;
            end
            ST_ERR2: s_resp = 1'b1;
            default: ;
        endcase
    end

    ahbl_reg_bank #(
        .WORDS  (MEM_WORDS),
        .DATA_W (DATA_W),
        .STRB_W (STRB_W),
        .IDX_W  (IDX_W)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .widx  (cap_idx),
        .lanes (cap_lanes),
        .wdata (s_wdata),
        .ridx  (cap_idx),
        .rdata (mem_rdata)
    );

endmodule

// File: rtl/ahbl_wait_mem_chk.sv
module ahbl_wait_mem_chk #(
    parameter int WAIT_STATES = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       s_sel,
    input logic [1:0] s_trans,
    input logic       s_ready_in,
    input logic       s_ready_out,
    input logic       s_resp
);

    localparam int MAX_LOW = (WAIT_STATES > 0) ? WAIT_STATES : 1;
    localparam int RUN_W   = $clog2(MAX_LOW + 2) + 1;

    // Number of earlier consecutive low-ready cycles in the current run
    logic [RUN_W-1:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (!s_ready_out) begin
            if (low_run != '1) low_run <= low_run + 1'b1;
        end else begin
            low_run <= '0;
        end
    end

    // R3: a stretched data phase never exceeds the configured wait count
    a_r3_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
        !s_ready_out |-> (low_run < RUN_W'(MAX_LOW)));

    // R6: the low-ready error cycle is followed by the high-ready error cycle
    a_r6_err_second: assert property (@(posedge clk) disable iff (!rst_n)
        (s_resp && !s_ready_out) |=> (s_resp && s_ready_out));

    // R6: an error response always opens with ready low
    a_r6_err_opens_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_resp) |-> !s_ready_out);

    // R7: IDLE and BUSY get an immediate OKAY
    a_r7_idle_busy_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (s_sel && s_ready_in && s_ready_out && !s_trans[1]) |=> (s_ready_out && !s_resp));

    // R2: nothing starts while the bus-wide ready is low
    a_r2_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ready_out && !s_ready_in) |=> (s_ready_out && !s_resp));

endmodule

bind ahbl_wait_mem ahbl_wait_mem_chk #(
    .WAIT_STATES (WAIT_STATES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .s_sel       (s_sel),
    .s_trans     (s_trans),
    .s_ready_in  (s_ready_in),
    .s_ready_out (s_ready_out),
    .s_resp      (s_resp)
);

// File: tb/test_ahbl_wait_mem.sv
`timescale 1ns/1ps
module test_ahbl_wait_mem;

    localparam int WAITS = 2;
    localparam int WORDS = 16;
    localparam int NVEC  = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_sel = 1'b0;
    logic [31:0] s_addr = '0;
    logic [1:0]  s_trans = 2'b00;
    logic        s_write = 1'b0;
    logic [2:0]  s_size = 3'd0;
    logic [31:0] s_wdata = '0;
    logic        hold_low = 1'b0;
    logic        s_ready_out;
    logic        s_resp;
    logic [31:0] s_rdata;
    wire         s_ready_in = hold_low ? 1'b0 : s_ready_out;

    int n_checks = 0;
    int n_fails  = 0;
    logic [31:0] shadow [WORDS];

    always #2 clk = ~clk;

    ahbl_wait_mem #(.WAIT_STATES(WAITS)) i_ahbl_wait_mem (
        .clk(clk), .rst_n(rst_n), .s_sel(s_sel), .s_addr(s_addr),
        .s_trans(s_trans), .s_write(s_write), .s_size(s_size),
        .s_wdata(s_wdata), .s_ready_in(s_ready_in),
        .s_ready_out(s_ready_out), .s_resp(s_resp), .s_rdata(s_rdata)
    );

    // vector: [44] write, [43:41] size, [40:33] addr, [32:1] data, [0] error
    localparam logic [44:0] VEC [NVEC] = '{
        {1'b1, 3'd2, 8'h00, 32'h11223344, 1'b0},
        {1'b1, 3'd0, 8'h05, 32'h0000AB00, 1'b0},
        {1'b1, 3'd1, 8'h06, 32'hCDEF0000, 1'b0},
        {1'b0, 3'd2, 8'h04, 32'h00000000, 1'b0},
        {1'b1, 3'd2, 8'h40, 32'hFFFFFFFF, 1'b1},
        {1'b1, 3'd1, 8'h09, 32'hFFFFFFFF, 1'b1},
        {1'b0, 3'd3, 8'h00, 32'h00000000, 1'b1},
        {1'b0, 3'd0, 8'h00, 32'h00000000, 1'b0},
        {1'b1, 3'd2, 8'h3C, 32'hDEADBEEF, 1'b0},
        {1'b0, 3'd2, 8'h3C, 32'h00000000, 1'b0},
        {1'b0, 3'd2, 8'h08, 32'h00000000, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // Model update per R4: lane k written when addr[1:0] <= k < addr[1:0] + 2**size
    task automatic model_write(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] d);
        for (int b = 0; b < 4; b++) begin
            if (b >= int'(a[1:0]) && b < int'(a[1:0]) + (1 << sz))
                shadow[a[7:2]][b*8 +: 8] = d[b*8 +: 8];
        end
    endtask

    // Call just after a negedge: present an address phase
    task automatic addr_phase(input logic wr, input logic [2:0] sz, input logic [31:0] a);
        s_sel = 1'b1; s_trans = 2'b10; s_write = wr; s_size = sz; s_addr = a;
    endtask

    // Run a data phase; returns at the negedge of the completing cycle
    task automatic data_phase(input logic [31:0] d, output int waits, output logic low_resp,
                              output logic end_resp, output logic [31:0] rd);
        @(posedge clk);
        @(negedge clk);
        s_sel = 1'b0; s_trans = 2'b00; s_wdata = d;
        waits = 0; low_resp = 1'b0;
        while (!s_ready_out) begin
            low_resp = low_resp | s_resp;
            waits++;
            @(negedge clk);
        end
        end_resp = s_resp;
        rd = s_rdata;
    endtask

    task automatic do_read(input logic [31:0] a, output logic [31:0] rd);
        int w; logic lr, er;
        @(negedge clk);
        addr_phase(1'b0, 3'd2, a);
        data_phase(32'h0, w, lr, er, rd);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        finish_up();
    end

    initial begin
        int w; logic lr, er; logic [31:0] rd;
        for (int i = 0; i < WORDS; i++) shadow[i] = '0;

        // R1: outputs while in reset and just after release
        repeat (3) @(negedge clk);
        check("R1 ready in reset", {31'b0, s_ready_out}, 32'h1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", {31'b0, s_ready_out}, 32'h1);
        check("R1 resp after reset", {31'b0, s_resp}, 32'h0);

        // Table walk: R3 wait count, R4 lanes, R5 read, R6 errors
        for (int i = 0; i < NVEC; i++) begin
            logic        vw;
            logic [2:0]  vs;
            logic [7:0]  va;
            logic [31:0] vd;
            logic        ve;
            {vw, vs, va, vd, ve} = VEC[i];
            @(negedge clk);
            addr_phase(vw, vs, {24'h0, va});
            data_phase(vd, w, lr, er, rd);
            if (ve) begin
                check("R6 error low cycles", w, 32'd1);
                check("R6 resp while low", {31'b0, lr}, 32'h1);
                check("R6 resp at end", {31'b0, er}, 32'h1);
            end else begin
                check("R3 wait cycles", w, WAITS);
                check("R3 okay at end", {31'b0, er}, 32'h0);
                if (vw) model_write(va, vs, vd);
                else check("R5 read data", rd, shadow[va[7:2]]);
            end
        end

        // R2: phase shown while bus ready is held low, withdrawn before release
        @(negedge clk);
        hold_low = 1'b1;
        addr_phase(1'b1, 3'd2, 32'h20);
        s_wdata = 32'hFFFFFFFF;
        @(negedge clk);
        check("R2 no start under held ready", {31'b0, s_ready_out}, 32'h1);
        s_sel = 1'b0; s_trans = 2'b00;
        @(negedge clk);
        hold_low = 1'b0;
        @(negedge clk);
        do_read(32'h20, rd);
        check("R2 no write under held ready", rd, 32'h0);

        // R7: BUSY write and IDLE write are ignored
        @(negedge clk);
        addr_phase(1'b1, 3'd2, 32'h24);
        s_trans = 2'b01;
        s_wdata = 32'h5A5A5A5A;
        @(negedge clk);
        check("R7 busy ready", {31'b0, s_ready_out}, 32'h1);
        check("R7 busy resp", {31'b0, s_resp}, 32'h0);
        s_trans = 2'b00;
        @(negedge clk);
        check("R7 idle ready", {31'b0, s_ready_out}, 32'h1);
        s_sel = 1'b0;
        do_read(32'h24, rd);
        check("R7 no write", rd, 32'h0);

        // R8: read shown in the completing cycle of a write to the same word
        @(negedge clk);
        addr_phase(1'b1, 3'd2, 32'h10);
        data_phase(32'hA1B2C3D4, w, lr, er, rd);
        addr_phase(1'b0, 3'd2, 32'h10);
        data_phase(32'h0, w, lr, er, rd);
        model_write(8'h10, 3'd2, 32'hA1B2C3D4);
        check("R8 pipelined wait cycles", w, WAITS);
        check("R8 pipelined read", rd, 32'hA1B2C3D4);

        // R9: asynchronous reset inside a wait cycle, then R1 memory cleared
        @(negedge clk);
        addr_phase(1'b0, 3'd2, 32'h3C);
        @(posedge clk);
        @(negedge clk);
        s_sel = 1'b0; s_trans = 2'b00;
        check("R9 in wait before reset", {31'b0, s_ready_out}, 32'h0);
        #0.5 rst_n = 1'b0;
        #0.5 check("R9 ready at once", {31'b0, s_ready_out}, 32'h1);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < WORDS; i++) shadow[i] = '0;
        do_read(32'h3C, rd);
        check("R1 memory cleared", rd, 32'h0);

        @(negedge clk);
        finish_up();
    end

endmodule